// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block is the counting heart of a real-time clock. It holds seconds, minutes, hours (24-hour form), day of month, weekday, month and a two-digit year, each as packed BCD. The fields advance on a one-pulse-per-second input. Every carry is a single-cycle enable into the next field, so one tick can ripple from seconds to year within a single clock. Month length follows the calendar, and February gains a 29th day in years divisible by four.

Software sees ten byte-wide registers through a plain port with address, write data, write strobe and combinational read data. Three control registers sit at 0x00 to 0x02 and the seven time registers at 0x03 to 0x09. A freeze bit halts all counting, so a new time can be loaded over several writes without a tick landing part-way through. A sticky status bit in the seconds register records that the timebase was lost. A seconds event flag is set on every counted tick and can be routed to an interrupt output.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time fields hold the INIT_* parameter values. The oscillator-lost bit (bit 7 of 0x03) is 1. Register 0x00 and register 0x01 read 0.
- R2: Each counted tick adds one to seconds in BCD. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the day.
- R3: On an hour carry the day steps to 01 once it has reached the month's last day. That day is 30 for months 04, 06, 09 and 11, 29 for month 02 when the BCD year is divisible by 4, 28 for month 02 otherwise, and 31 for all other months. At that point the month steps, and month 12 wraps to 01 with a carry into the year. Year 99 wraps to 00.
- R4: The weekday (0x07, values 0 to 6) steps on every hour carry, and 6 wraps to 0.
- R5: Every field affected by a tick shows its new value on the clock cycle after the tick is sampled, including a full ripple from seconds to year.
- R6: While the stop bit (bit 5 of 0x00) is 1, ticks change no time field and do not set the seconds flag. Register writes still take effect.
- R7: Read data is 0x00 {bit5 stop, bit2 seconds-interrupt enable}, 0x01 {bit4 seconds flag}, 0x03 {bit7 oscillator-lost, bits 6:0 seconds}, 0x04 minutes (7 bits), 0x05 hours (6 bits), 0x06 day (6 bits), 0x07 weekday (3 bits), 0x08 month (5 bits), 0x09 year (8 bits). Every other bit reads 0. This includes bit 3 of 0x00 (12/24-hour select, fixed to 24-hour), all of 0x02, and addresses 0x0A to 0x0F. Writes to those bits are ignored.
- R8: The oscillator-lost bit is set by reset and by osc_lost_i. A write to 0x03 with bit 7 = 0 clears it. A write with bit 7 = 1 leaves it set. If osc_lost_i is high in the same cycle as the write, the bit stays set.
- R9: The seconds flag (bit 4 of 0x01) is set by each counted tick. Writing 0x01 with bit 4 = 0 clears it, and writing bit 4 = 1 has no effect. A counted tick in the same cycle as a clearing write leaves the flag set.
- R10: irq_o is 1 exactly when the seconds flag and the seconds-interrupt enable are both 1.
- R11: When a time register is written in the same cycle as a counted tick, the written value is stored in that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| osc_lost_i | input | 1 | Timebase-loss indication, sets the sticky status bit |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Seconds event interrupt |

## Verification
The bench builds the core with reset-time parameters of 23:59:55 on day 31 of month 12, year 99, weekday 6. This puts a full year-to-year ripple five ticks after start. It then loads times just before February 28/29 in leap and common years (including year 00), just before the 30-day month end, and just before a midnight. A long run of irregular ticks from 23:40 with occasional flag clears crosses several minute boundaries and one day boundary. Throughout, the bench compares the read port and interrupt against a binary-arithmetic calendar model on every clock.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int NUM_REGS = 10;
  // register addresses (decoded by software; order is the burst order)
  localparam int A_CTL0 = 0;
  localparam int A_CTL1 = 1;
  localparam int A_SEC  = 3;
  localparam int A_MIN  = 4;
  localparam int A_HOUR = 5;
  localparam int A_DAY  = 6;
  localparam int A_WDAY = 7;
  localparam int A_MON  = 8;
  localparam int A_YEAR = 9;
  // bit positions
  localparam int B_STOP = 5;
  localparam int B_SIE  = 2;
  localparam int B_SFLG = 4;
  localparam int B_OSC  = 7;
  // field widths
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DAY_W  = 6;
  localparam int WDAY_W = 3;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;

  // next BCD value, no wrap handling
  function automatic bcd8_t bcd_succ(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four
  function automatic logic leap_year(bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // last valid day of a BCD month
  function automatic bcd8_t month_last_day(bcd8_t m, bcd8_t y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic at_top(bcd8_t v, bcd8_t top);
    return v >= top;
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_bcd_pkg::*;
#(
  parameter int    W   = 7,
  parameter bcd8_t LO  = 8'h00,
  parameter bcd8_t RST = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  bcd8_t        max_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] nxt;
  bcd8_t        ext;

  always_comb begin
    ext = '0;
    ext[W-1:0] = val_q;
    nxt = at_top(ext, max_i) ? LO[W-1:0] : W'(bcd_succ(ext));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST[W-1:0];
    else if (wr_i)   val_q <= wdata_i;
    else if (inc_i)  val_q <= nxt;
  end

  assign val_o = val_q;

  a_r6_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(val_q));
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (val_q == $past(wdata_i)));
  a_r2_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i && (ext >= max_i)) |=> (val_q == LO[W-1:0]));
endmodule

// File: rtl/rtc_bcd_ctrl.sv
module rtc_bcd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic osc_lost_i,
  input  logic wr_ctl0_i,
  input  logic wr_ctl1_i,
  input  logic wr_sec_i,
  input  logic stop_wbit_i,
  input  logic sie_wbit_i,
  input  logic sflg_wbit_i,
  input  logic osc_wbit_i,
  output logic stop_o,
  output logic sie_o,
  output logic sflg_o,
  output logic osc_o,
  output logic step_o,
  output logic irq_o
);
  logic stop_q, sie_q, sflg_q, osc_q;

  assign step_o = tick_i && !stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      sie_q  <= 1'b0;
      sflg_q <= 1'b0;
      osc_q  <= 1'b1;
    end else begin
      if (wr_ctl0_i) begin
        stop_q <= stop_wbit_i;
        sie_q  <= sie_wbit_i;
      end
      if (step_o)                       sflg_q <= 1'b1;
      else if (wr_ctl1_i && !sflg_wbit_i) sflg_q <= 1'b0;
      if (osc_lost_i)                   osc_q <= 1'b1;
      else if (wr_sec_i && !osc_wbit_i) osc_q <= 1'b0;
    end
  end

  assign stop_o = stop_q;
  assign sie_o  = sie_q;
  assign sflg_o = sflg_q;
  assign osc_o  = osc_q;
  assign irq_o  = sflg_q && sie_q;

  a_r9_flag_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_q) |=> sflg_q);
  a_r6_no_flag_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !sflg_q) |=> !sflg_q);
  a_r8_osc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    osc_lost_i |=> osc_q);
  a_r8_osc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sec_i && !osc_wbit_i && !osc_lost_i) |=> !osc_q);
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter int    ADDR_W    = 4,
  parameter bcd8_t INIT_SEC  = 8'h00,
  parameter bcd8_t INIT_MIN  = 8'h00,
  parameter bcd8_t INIT_HOUR = 8'h00,
  parameter bcd8_t INIT_DAY  = 8'h01,
  parameter bcd8_t INIT_WDAY = 8'h00,
  parameter bcd8_t INIT_MON  = 8'h01,
  parameter bcd8_t INIT_YEAR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              osc_lost_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] wr_sel;
  logic stop, sie, sflg, osc, step;
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  mnt;
  logic [HOUR_W-1:0] hr;
  logic [DAY_W-1:0]  dy;
  logic [WDAY_W-1:0] wd;
  logic [MON_W-1:0]  mo;
  logic [YEAR_W-1:0] yr;
  // carry events between fields, kept visible for checks
  logic sec_c, min_c, hour_c, day_c, mon_c;
  bcd8_t day_top;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      wr_sel[i] = wr_i && (addr_i == ADDR_W'(i));
  end

  rtc_bcd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_lost_i(osc_lost_i),
    .wr_ctl0_i(wr_sel[A_CTL0]), .wr_ctl1_i(wr_sel[A_CTL1]), .wr_sec_i(wr_sel[A_SEC]),
    .stop_wbit_i(wdata_i[B_STOP]), .sie_wbit_i(wdata_i[B_SIE]),
    .sflg_wbit_i(wdata_i[B_SFLG]), .osc_wbit_i(wdata_i[B_OSC]),
    .stop_o(stop), .sie_o(sie), .sflg_o(sflg), .osc_o(osc),
    .step_o(step), .irq_o(irq_o)
  );

  always_comb begin
    day_top = month_last_day(8'(mo), yr);
    sec_c   = step   && at_top(8'(sec), 8'h59);
    min_c   = sec_c  && at_top(8'(mnt), 8'h59);
    hour_c  = min_c  && at_top(8'(hr),  8'h23);
    day_c   = hour_c && at_top(8'(dy),  day_top);
    mon_c   = day_c  && at_top(8'(mo),  8'h12);
  end

  rtc_bcd_field #(.W(SEC_W), .LO(8'h00), .RST(INIT_SEC)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(step), .max_i(8'h59),
    .wr_i(wr_sel[A_SEC]), .wdata_i(wdata_i[SEC_W-1:0]), .val_o(sec));
  rtc_bcd_field #(.W(MIN_W), .LO(8'h00), .RST(INIT_MIN)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(sec_c), .max_i(8'h59),
    .wr_i(wr_sel[A_MIN]), .wdata_i(wdata_i[MIN_W-1:0]), .val_o(mnt));
  rtc_bcd_field #(.W(HOUR_W), .LO(8'h00), .RST(INIT_HOUR)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc_i(min_c), .max_i(8'h23),
    .wr_i(wr_sel[A_HOUR]), .wdata_i(wdata_i[HOUR_W-1:0]), .val_o(hr));
  rtc_bcd_field #(.W(DAY_W), .LO(8'h01), .RST(INIT_DAY)) u_day (
    .clk(clk), .rst_n(rst_n), .inc_i(hour_c), .max_i(day_top),
    .wr_i(wr_sel[A_DAY]), .wdata_i(wdata_i[DAY_W-1:0]), .val_o(dy));
  rtc_bcd_field #(.W(WDAY_W), .LO(8'h00), .RST(INIT_WDAY)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc_i(hour_c), .max_i(8'h06),
    .wr_i(wr_sel[A_WDAY]), .wdata_i(wdata_i[WDAY_W-1:0]), .val_o(wd));
  rtc_bcd_field #(.W(MON_W), .LO(8'h01), .RST(INIT_MON)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc_i(day_c), .max_i(8'h12),
    .wr_i(wr_sel[A_MON]), .wdata_i(wdata_i[MON_W-1:0]), .val_o(mo));
  rtc_bcd_field #(.W(YEAR_W), .LO(8'h00), .RST(INIT_YEAR)) u_year (
    .clk(clk), .rst_n(rst_n), .inc_i(mon_c), .max_i(8'h99),
    .wr_i(wr_sel[A_YEAR]), .wdata_i(wdata_i[YEAR_W-1:0]), .val_o(yr));

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      A_CTL0: begin
        rdata_o[B_STOP] = stop;
        rdata_o[B_SIE]  = sie;
      end
      A_CTL1: rdata_o[B_SFLG] = sflg;
      A_SEC:  rdata_o = {osc, sec};
      A_MIN:  rdata_o = 8'(mnt);
      A_HOUR: rdata_o = 8'(hr);
      A_DAY:  rdata_o = 8'(dy);
      A_WDAY: rdata_o = 8'(wd);
      A_MON:  rdata_o = 8'(mo);
      A_YEAR: rdata_o = yr;
      default: rdata_o = '0;
    endcase
  end

  a_r6_seconds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_sel[A_SEC]) |=> $stable(sec));
  a_r5_minute_ripple: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_c && !wr_sel[A_MIN] && !wr_sel[A_SEC]) |=> (sec == '0 && $changed(mnt)));
  a_r3_month_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_c && !wr_sel[A_MON]) |=> (mo == 5'h01));
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, osc_lost_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic irq_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rtc_bcd_core #(.ADDR_W(4), .INIT_SEC(8'h55), .INIT_MIN(8'h59), .INIT_HOUR(8'h23),
    .INIT_DAY(8'h31), .INIT_WDAY(8'h06), .INIT_MON(8'h12), .INIT_YEAR(8'h99)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_lost_i(osc_lost_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i), .rdata_o(rdata_o), .irq_o(irq_o));

  // ---------------- reference calendar (binary integers) ----------------
  int ms, mm, mh, md, mw, mmo, my;
  bit mstop, msie, msf, mosc;

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic int b2i(logic [7:0] x); return x[7:4] * 10 + x[3:0]; endfunction
  function automatic logic [7:0] i2b(int n); return 8'(((n / 10) << 4) | (n % 10)); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 55; mm = 59; mh = 23; md = 31; mw = 6; mmo = 12; my = 99;
      mstop = 0; msie = 0; msf = 0; mosc = 1;
    end else begin
      bit st;
      st = tick_i && !mstop;
      if (st) begin
        msf = 1;
        if (ms == 59) begin
          ms = 0;
          if (mm == 59) begin
            mm = 0;
            if (mh == 23) begin
              mh = 0;
              mw = (mw == 6) ? 0 : mw + 1;
              if (md >= dim(mmo, my)) begin
                md = 1;
                if (mmo == 12) begin mmo = 1; my = (my == 99) ? 0 : my + 1; end
                else mmo++;
              end else md++;
            end else mh++;
          end else mm++;
        end else ms++;
      end
      if (wr_i) case (addr_i)
        4'd0: begin mstop = wdata_i[5]; msie = wdata_i[2]; end
        4'd1: if (!wdata_i[4] && !st) msf = 0;
        4'd3: begin ms = b2i(wdata_i & 8'h7F); if (!wdata_i[7]) mosc = 0; end
        4'd4: mm = b2i(wdata_i & 8'h7F);
        4'd5: mh = b2i(wdata_i & 8'h3F);
        4'd6: md = b2i(wdata_i & 8'h3F);
        4'd7: mw = b2i(wdata_i & 8'h07);
        4'd8: mmo = b2i(wdata_i & 8'h1F);
        4'd9: my = b2i(wdata_i);
        default: ;
      endcase
      if (osc_lost_i) mosc = 1;
    end
  end

  function automatic logic [7:0] model_read(logic [3:0] a);
    case (a)
      4'd0: return 8'({mstop, 2'b00, msie, 2'b00});
      4'd1: return 8'({msf, 4'b0000});
      4'd3: return {mosc, 7'(i2b(ms))};
      4'd4: return i2b(mm);
      4'd5: return i2b(mh);
      4'd6: return i2b(md);
      4'd7: return i2b(mw);
      4'd8: return i2b(mmo);
      4'd9: return i2b(my);
      default: return 8'h00;
    endcase
  endfunction
  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0: return "R6"; 4'd1: return "R9"; 4'd3, 4'd4, 4'd5: return "R2";
      4'd6, 4'd8, 4'd9: return "R3"; 4'd7: return "R4"; default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock; compare read port and irq with the model at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check(tag_of(addr_i), rdata_o, model_read(addr_i));
      check("R10", 8'(irq_o), 8'(msf && msie));
    end
  endtask

  task automatic drive(logic tk, logic w, logic [3:0] a, logic [7:0] d, logic lost);
    tick_i = tk; wr_i = w; addr_i = a; wdata_i = d; osc_lost_i = lost;
    cyc();
    tick_i = 0; wr_i = 0; osc_lost_i = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp);
  endtask

  task automatic load(logic [7:0] y, logic [7:0] mo, logic [7:0] d,
                      logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    drive(0, 1, 4'd0, 8'h20, 0);
    drive(0, 1, 4'd9, y, 0);  drive(0, 1, 4'd8, mo, 0); drive(0, 1, 4'd6, d, 0);
    drive(0, 1, 4'd5, h, 0);  drive(0, 1, 4'd4, mi, 0); drive(0, 1, 4'd3, s, 0);
    drive(0, 1, 4'd0, 8'h00, 0);
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd3, 8'hD5, "R1"); rd(4'd4, 8'h59, "R1"); rd(4'd9, 8'h99, "R1");
    rd(4'd7, 8'h06, "R1"); rd(4'd0, 8'h00, "R1"); rd(4'd1, 8'h00, "R1");
    // R7 ignored bits, R6 freeze
    drive(0, 1, 4'd0, 8'h2C, 0);
    rd(4'd0, 8'h24, "R7");
    drive(1, 0, 4'd3, 0, 0); drive(1, 0, 4'd3, 0, 0); drive(1, 0, 4'd1, 0, 0);
    rd(4'd3, 8'hD5, "R6"); rd(4'd1, 8'h00, "R6");
    drive(0, 1, 4'd3, 8'h57, 0);
    rd(4'd3, 8'h57, "R8");
    drive(0, 1, 4'd0, 8'h04, 0);
    drive(1, 0, 4'd3, 0, 0);
    rd(4'd1, 8'h10, "R9"); check("R10", 8'(irq_o), 8'h01);
    drive(0, 1, 4'd1, 8'hFF, 0);
    rd(4'd1, 8'h10, "R9");
    drive(0, 1, 4'd1, 8'h00, 0);
    rd(4'd1, 8'h00, "R9"); check("R10", 8'(irq_o), 8'h00);
    drive(1, 0, 4'd3, 0, 0);
    drive(1, 0, 4'd3, 0, 0);
    // R5: full ripple visible one clock after the tick
    rd(4'd3, 8'h00, "R5"); rd(4'd4, 8'h00, "R2"); rd(4'd5, 8'h00, "R2");
    rd(4'd6, 8'h01, "R3"); rd(4'd7, 8'h00, "R4"); rd(4'd8, 8'h01, "R3");
    rd(4'd9, 8'h00, "R5");
    // R3 month ends
    load(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); drive(1, 0, 4'd6, 0, 0);
    rd(4'd6, 8'h29, "R3"); rd(4'd8, 8'h02, "R3");
    load(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); drive(1, 0, 4'd6, 0, 0);
    rd(4'd6, 8'h01, "R3"); rd(4'd8, 8'h03, "R3");
    load(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); drive(1, 0, 4'd6, 0, 0);
    rd(4'd6, 8'h01, "R3"); rd(4'd8, 8'h03, "R3");
    load(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); drive(1, 0, 4'd6, 0, 0);
    rd(4'd6, 8'h29, "R3");
    load(8'h41, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); drive(1, 0, 4'd6, 0, 0);
    rd(4'd6, 8'h01, "R3"); rd(4'd8, 8'h05, "R3");
    // R8 oscillator-lost handling
    drive(0, 0, 4'd3, 0, 1);
    rd(4'd3, 8'h80, "R8");
    drive(0, 1, 4'd3, 8'h90, 0); rd(4'd3, 8'h90, "R8");
    drive(0, 1, 4'd3, 8'h10, 1); rd(4'd3, 8'h90, "R8");
    drive(0, 1, 4'd3, 8'h10, 0); rd(4'd3, 8'h10, "R8");
    // R11 write beats tick; R9 tick beats clear
    drive(1, 1, 4'd3, 8'h30, 0); rd(4'd3, 8'h30, "R11");
    drive(1, 1, 4'd1, 8'h00, 0); rd(4'd1, 8'h10, "R9");
    // R7 unused addresses
    drive(0, 1, 4'd2, 8'hFF, 0);
    rd(4'd2, 8'h00, "R7"); rd(4'd10, 8'h00, "R7"); rd(4'd15, 8'h00, "R7");
    // long irregular run, compared every clock
    load(8'h99, 8'h12, 8'h31, 8'h23, 8'h40, 8'h00);
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] a;
      a = 4'(3 + (i % 7));
      if (i % 97 == 13) drive(0, 1, 4'd1, 8'h00, 0);
      else drive(1'(($urandom % 3) != 0), 0, a, 0, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule